// File: doc/BRIEF.md
# Parallel EEPROM Byte Programmer

This block sits on the host side of a byte-wide EEPROM that is accessed like a static RAM. It takes one command at a time over a valid/ready handshake. A command is either a byte write (13-bit address plus 8-bit data) or a byte read. For a write, the block drives chip enable, write enable and the data bus through timed setup, strobe and hold phases. During all three phases output enable stays high.

After the strobe the memory runs its own internal program cycle. The controller waits for that cycle to finish before it takes another command. In polling mode it reads the same address again and again, and it treats the cycle as finished when bit 7 of the read data equals bit 7 of the data written. In ready/busy mode it watches an open-drain status line, which has an external pull-up, through a synchronizer. The cycle is finished when that line goes high.

Once the cycle is finished, a final full-byte read is compared with the written byte. Every command ends with a single-cycle response that carries the read data, a timeout flag and a compare-mismatch flag. A wait that runs past a programmable limit ends the command with the timeout flag set. All pulse widths and intervals are parameters counted in clock cycles.

Top module: `eeprom_prog_ctrl`

## Requirements
- R1: After reset, chip enable, output enable and write enable are all high (inactive), the data bus driver is off, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: Write enable goes low only while chip enable is low, output enable is high and the data bus is driven. The address does not change while write enable is low, and each strobe lasts exactly `T_PULSE` cycles (4 by default).
- R3: The write data is driven unchanged through the strobe and is still driven in the cycle in which write enable returns high, so the memory stores exactly the requested byte.
- R4: Output enable is never low while the data bus is driven, or in the first cycle after the driver turns off.
- R5: With `mode`=0 (polling), a write completes only after a read of the written address returns bit 7 equal to bit 7 of the written data. Bits 6..0 of those reads and the ready/busy line are ignored.
- R6: With `mode`=1 (ready/busy), a write completes only after the synchronized `mem_rdy` line is high. Read data seen during the wait is ignored.
- R7: `cmd_ready` stays 0 from the acceptance of a command until its response, so no new access starts before the end of the current write cycle has been detected.
- R8: If completion is not detected within `TIMEOUT` cycles (2000 by default) after the write phases end, the response carries `rsp_timeout`=1 and the block returns to idle.
- R9: After completion, a final full-byte read of the written address is made. `rsp_mismatch` is 1 exactly when that byte differs from the written data, and it is 0 for reads and timeouts.
- R10: A read command (`cmd_write`=0) returns the byte stored at `cmd_addr` on `rsp_rdata`, with `rsp_timeout`=0.
- R11: `rsp_valid` is a single-cycle pulse, one for each accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | Completion detection: 0 = bit-7 polling, 1 = ready/busy line; sampled at accept |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle and able to accept |
| cmd_write | input | 1 | 1 = byte write, 0 = byte read |
| cmd_addr | input | 13 | Target address |
| cmd_wdata | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 8 | Byte from final read (write) or read command |
| rsp_timeout | output | 1 | Completion not seen within the limit |
| rsp_mismatch | output | 1 | Final read differs from written byte |
| mem_addr | output | 13 | Memory address bus |
| mem_dout | output | 8 | Data toward memory |
| mem_dout_en | output | 1 | Enable for the external data bus driver |
| mem_din | input | 8 | Data from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_rdy | input | 1 | Open-drain ready/busy line, high = ready |

## Verification
On every cycle, assertions check the strobe rules: write enable low only with chip enable low, output enable high and the bus driven, a steady address and steady data at the rising edge. They also check that the bus driver and output enable never overlap with less than a cycle of gap, that no command is accepted outside idle, and that each response is a single pulse. Some behaviours can only be shown by the scenarios, because they depend on a memory that takes many cycles to program. These are the exact strobe length, that completion waits for bit 7 even when the low bits, or a lying status line, look finished, the ready/busy path with misleading poll data, the timeout window, and the compare against a memory that stores a corrupted byte.

// File: rtl/eprg_pkg.sv
package eprg_pkg;
  typedef enum logic [3:0] {
    S_IDLE,  // waiting for a command
    S_WSET,  // address/data set up, strobe not yet low
    S_WPUL,  // write strobe low
    S_WHLD,  // strobe released, data still driven
    S_WTRN,  // bus released, turnaround
    S_GAP,   // deselected pause between status checks
    S_PRD,   // poll read of bit 7
    S_RBW,   // wait on ready/busy line
    S_FRD,   // final full-byte read for compare
    S_RRD    // plain read command
  } eprg_st_e;
endpackage

// File: rtl/eprg_cnt.sv
module eprg_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= val;
    else if (en && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/eprg_sync.sv
module eprg_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[i] <= {W{RST_VAL}};
        else     stg_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[i] <= {W{RST_VAL}};
        else     stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int T_SETUP     = 2,
  parameter int T_PULSE     = 4,
  parameter int T_HOLD      = 2,
  parameter int T_READ      = 3,
  parameter int T_GAP       = 4,
  parameter int TIMEOUT     = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  output logic              rsp_mismatch,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  input  logic              mem_rdy
);
  import eprg_pkg::*;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PH_MAX = max_of(max_of(T_SETUP, T_PULSE), max_of(max_of(T_HOLD, T_READ), T_GAP));
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int TO_W   = $clog2(TIMEOUT + 1);
  localparam int MSB    = DATA_W - 1;

  eprg_st_e          state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              mode_q;
  logic              ph_load, ph_zero, to_load, to_en, to_zero;
  logic [PH_W-1:0]   ph_val;
  logic              accept, fin, fin_to, fin_cmp;
  logic              rdy_s;
  logic              ce_n_q, oe_n_q, we_n_q, dout_en_q;
  logic              rsp_valid_q, rsp_to_q, rsp_mis_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  eprg_cnt #(.W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .val(ph_val), .en(1'b1), .zero(ph_zero)
  );

  eprg_cnt #(.W(TO_W)) u_timeout (
    .clk(clk), .rst(rst), .load(to_load), .val(TO_W'(TIMEOUT - 1)), .en(to_en), .zero(to_zero)
  );

  eprg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
    .clk(clk), .rst(rst), .d(mem_rdy), .q(rdy_s)
  );

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    to_load = 1'b0;
    to_en   = 1'b0;
    accept  = 1'b0;
    fin     = 1'b0;
    fin_to  = 1'b0;
    fin_cmp = 1'b0;
    case (state_q)
      S_IDLE: if (cmd_valid) begin
        accept  = 1'b1;
        ph_load = 1'b1;
        if (cmd_write) begin
          state_d = S_WSET;
          ph_val  = PH_W'(T_SETUP - 1);
        end else begin
          state_d = S_RRD;
          ph_val  = PH_W'(T_READ - 1);
        end
      end
      S_WSET: if (ph_zero) begin
        state_d = S_WPUL;
        ph_load = 1'b1;
        ph_val  = PH_W'(T_PULSE - 1);
      end
      S_WPUL: if (ph_zero) begin
        state_d = S_WHLD;
        ph_load = 1'b1;
        ph_val  = PH_W'(T_HOLD - 1);
      end
      S_WHLD: if (ph_zero) state_d = S_WTRN;
      S_WTRN: begin
        state_d = S_GAP;
        ph_load = 1'b1;
        ph_val  = PH_W'(T_GAP - 1);
        to_load = 1'b1;
      end
      S_GAP: begin
        to_en = 1'b1;
        if (to_zero) begin
          state_d = S_IDLE;
          fin     = 1'b1;
          fin_to  = 1'b1;
        end else if (ph_zero) begin
          ph_load = 1'b1;
          if (mode_q) begin
            state_d = S_RBW;
          end else begin
            state_d = S_PRD;
            ph_val  = PH_W'(T_READ - 1);
          end
        end
      end
      S_PRD: begin
        to_en = 1'b1;
        if (to_zero) begin
          state_d = S_IDLE;
          fin     = 1'b1;
          fin_to  = 1'b1;
        end else if (ph_zero) begin
          ph_load = 1'b1;
          if (mem_din[MSB] == wdata_q[MSB]) begin
            state_d = S_FRD;
            ph_val  = PH_W'(T_READ - 1);
          end else begin
            state_d = S_GAP;
            ph_val  = PH_W'(T_GAP - 1);
          end
        end
      end
      S_RBW: begin
        to_en = 1'b1;
        if (to_zero) begin
          state_d = S_IDLE;
          fin     = 1'b1;
          fin_to  = 1'b1;
        end else if (rdy_s) begin
          state_d = S_FRD;
          ph_load = 1'b1;
          ph_val  = PH_W'(T_READ - 1);
        end
      end
      S_FRD: if (ph_zero) begin
        state_d = S_IDLE;
        fin     = 1'b1;
        fin_cmp = 1'b1;
      end
      S_RRD: if (ph_zero) begin
        state_d = S_IDLE;
        fin     = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      mode_q    <= 1'b0;
      ce_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      dout_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= cmd_addr;
        wdata_q <= cmd_wdata;
        mode_q  <= mode;
      end
      ce_n_q    <= !(state_d inside {S_WSET, S_WPUL, S_WHLD, S_PRD, S_FRD, S_RRD});
      oe_n_q    <= !(state_d inside {S_PRD, S_FRD, S_RRD});
      we_n_q    <= (state_d != S_WPUL);
      dout_en_q <= (state_d inside {S_WSET, S_WPUL, S_WHLD});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_to_q    <= 1'b0;
      rsp_mis_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= fin;
      if (fin) begin
        rsp_to_q    <= fin_to;
        rsp_mis_q   <= fin_cmp && (mem_din != wdata_q);
        rsp_rdata_q <= fin_to ? '0 : mem_din;
      end
    end
  end

  assign cmd_ready    = (state_q == S_IDLE);
  assign rsp_valid    = rsp_valid_q;
  assign rsp_rdata    = rsp_rdata_q;
  assign rsp_timeout  = rsp_to_q;
  assign rsp_mismatch = rsp_mis_q;
  assign mem_addr     = addr_q;
  assign mem_dout     = wdata_q;
  assign mem_dout_en  = dout_en_q;
  assign mem_ce_n     = ce_n_q;
  assign mem_oe_n     = oe_n_q;
  assign mem_we_n     = we_n_q;

  AST_STROBE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dout_en)); // R2
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> $stable(mem_addr)); // R2
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dout_en && $stable(mem_dout))); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_dout_en && !$past(mem_dout_en))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (mem_we_n && mem_oe_n && !mem_dout_en)); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R11
  AST_RSP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> cmd_ready); // R11
endmodule

// File: tb/eeprom_prog_ctrl_tb.sv
`timescale 1ns/1ps
module eeprom_prog_ctrl_tb_top;
  localparam int PULSE   = 4;
  localparam int TMO     = 2000;
  localparam int BUSY    = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [12:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        rsp_timeout, rsp_mismatch;
  logic [12:0] mem_addr;
  logic [7:0]  mem_dout, mem_din;
  logic        mem_dout_en, mem_ce_n, mem_oe_n, mem_we_n, mem_rdy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eeprom_prog_ctrl dut_i (
    .clk(clk), .rst(rst), .mode(mode),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .rsp_mismatch(rsp_mismatch),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_rdy(mem_rdy)
  );

  // Behavioural memory model, updated on the falling edge
  logic [7:0]  mem_m [256];
  logic        prev_we;
  int          busy_cnt, low_run, last_pulse, busy_end;
  logic [12:0] busy_addr;
  logic [7:0]  busy_data;
  logic        stuck = 1'b0, rdy_lies = 1'b0, poll_lies = 1'b0;
  logic [7:0]  corrupt = 8'h00;
  int          clash = 0;
  logic        busy;

  initial for (int i = 0; i < 256; i++) mem_m[i] = 8'(i * 7 + 3);

  assign busy    = (busy_cnt != 0) || stuck;
  assign mem_rdy = rdy_lies ? 1'b1 : !busy;
  assign mem_din = (mem_ce_n || mem_oe_n) ? 8'h00 :
                   (busy && !poll_lies && mem_addr == busy_addr) ? {~busy_data[7], busy_data[6:0]} :
                   mem_m[mem_addr[7:0]];

  always @(negedge clk) begin
    if (rst) begin
      prev_we  <= 1'b1;
      busy_cnt <= 0;
      low_run  <= 0;
    end else begin
      prev_we <= mem_we_n;
      if (!mem_oe_n && mem_dout_en) clash <= clash + 1;
      if (!mem_we_n) low_run <= low_run + 1;
      if (!prev_we && mem_we_n && !mem_ce_n && mem_oe_n) begin
        mem_m[mem_addr[7:0]] <= mem_dout ^ corrupt;
        busy_addr  <= mem_addr;
        busy_data  <= mem_dout;
        busy_cnt   <= BUSY;
        last_pulse <= low_run;
        low_run    <= 0;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
        if (busy_cnt == 1) busy_end <= cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic wr, input logic [12:0] a, input logic [7:0] d, input logic md,
                        output logic [7:0] rd, output logic to, output logic mm,
                        output int acc_c, output int rsp_c, output int early);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; mode = md;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    acc_c = cyc;
    #1 cmd_valid = 1'b0;
    early = 0;
    n = 0;
    @(negedge clk);
    while (!rsp_valid && n < 20000) begin
      if (cmd_ready) early++;
      @(negedge clk);
      n++;
    end
    rd = rsp_rdata; to = rsp_timeout; mm = rsp_mismatch; rsp_c = cyc;
    chk(rsp_valid == 1'b1, "R11 response seen", rsp_valid, 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 single pulse", rsp_valid, 0);
  endtask

  task automatic t_reset();
    chk(mem_ce_n == 1'b1, "R1 ce_n", mem_ce_n, 1);
    chk(mem_oe_n == 1'b1, "R1 oe_n", mem_oe_n, 1);
    chk(mem_we_n == 1'b1, "R1 we_n", mem_we_n, 1);
    chk(mem_dout_en == 1'b0, "R1 dout_en", mem_dout_en, 0);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_poll_write(input logic [12:0] a, input logic [7:0] d, input logic lie);
    logic [7:0] rd; logic to, mm; int ac, rc, early;
    rdy_lies = lie;
    do_cmd(1'b1, a, d, 1'b0, rd, to, mm, ac, rc, early);
    chk(last_pulse == PULSE, "R2 strobe length", last_pulse, PULSE);
    chk(mem_m[a[7:0]] == d, "R3 stored byte", mem_m[a[7:0]], d);
    chk(rc > busy_end, "R5 poll waits for bit7", rc, busy_end + 1);
    chk(early == 0, "R7 ready held low", early, 0);
    chk(to == 1'b0, "R8 no timeout", to, 0);
    chk(mm == 1'b0 && rd == d, "R9 verify matches", rd, d);
    rdy_lies = 1'b0;
  endtask

  task automatic t_rb_write(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] rd; logic to, mm; int ac, rc, early;
    poll_lies = 1'b1;
    do_cmd(1'b1, a, d, 1'b1, rd, to, mm, ac, rc, early);
    chk(rc > busy_end, "R6 waits for ready line", rc, busy_end + 1);
    chk(to == 1'b0 && mm == 1'b0, "R6 clean completion", {to, mm}, 0);
    chk(early == 0, "R7 ready held low rb", early, 0);
    poll_lies = 1'b0;
  endtask

  task automatic t_read(input logic [12:0] a);
    logic [7:0] rd; logic to, mm; int ac, rc, early;
    logic [7:0] exp_v;
    exp_v = mem_m[a[7:0]];
    do_cmd(1'b0, a, 8'h00, 1'b0, rd, to, mm, ac, rc, early);
    chk(rd == exp_v, "R10 read data", rd, exp_v);
    chk(to == 1'b0 && mm == 1'b0, "R10 read flags", {to, mm}, 0);
  endtask

  task automatic t_mismatch();
    logic [7:0] rd; logic to, mm; int ac, rc, early;
    corrupt = 8'h01;
    do_cmd(1'b1, 13'h0A7, 8'h81, 1'b0, rd, to, mm, ac, rc, early);
    chk(mm == 1'b1, "R9 mismatch flagged", mm, 1);
    chk(rd == 8'h80, "R9 final read value", rd, 8'h80);
    corrupt = 8'h00;
  endtask

  task automatic t_timeout(input logic md);
    logic [7:0] rd; logic to, mm; int ac, rc, early;
    stuck = 1'b1;
    do_cmd(1'b1, 13'h033, 8'h5A, md, rd, to, mm, ac, rc, early);
    chk(to == 1'b1, "R8 timeout flag", to, 1);
    chk(mm == 1'b0, "R9 no mismatch on timeout", mm, 0);
    chk((rc - ac) >= TMO && (rc - ac) <= TMO + 40, "R8 timeout window", rc - ac, TMO);
    chk(cmd_ready == 1'b1, "R8 back to idle", cmd_ready, 1);
    stuck = 1'b0;
    repeat (BUSY + 5) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_poll_write(13'h12A5, 8'hC3, 1'b0);
    t_poll_write(13'h0044, 8'h35, 1'b1);
    t_rb_write(13'h1E10, 8'h5E);
    t_rb_write(13'h0011, 8'hD2);
    t_read(13'h12A5);
    t_read(13'h0099);
    t_mismatch();
    t_timeout(1'b0);
    t_timeout(1'b1);
    chk(clash == 0, "R4 bus contention cycles", clash, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule